// File: doc/BRIEF.md
# Page Write Buffer with Deferred Commit

This block sits between the serial command decoder of a small non-volatile memory and its 512 x 8 storage array. When the decoder has taken a write opcode and a start address, it opens a frame. Each complete data byte that follows is parked in a 16-slot buffer covering one aligned page. A fill mask records which slots hold data. The in-page offset advances after every byte and wraps inside the page, so a long burst overwrites the bytes it wrote first.

Nothing reaches the array until the chip-select rising edge arrives as a commit strobe. It must come with the permit signal from the protection logic, and at least one complete byte must be held. The block then runs a self-timed programming cycle of a parameterised length. During that cycle it raises busy and writes only the filled slots through a plain synchronous RAM port, one slot per clock. At the end it pulses done and empties the buffer. An abort input, driven when the write-protect pin drops while chip select is still low, throws the open frame away. While busy, every frame input is ignored.

Top module: `pgbuf_commit`

## Requirements
- R1: After reset, busy, done and mem_we are all low.
- R2: start_vld while not busy opens a frame. The page is start_addr[8:4], the first offset is start_addr[3:0], and any bytes from an earlier open frame are discarded.
- R3: Each byte_vld in an open frame stores byte_data at {page, offset}. The offset then increments modulo 16 and the page bits stay unchanged.
- R4: More than 16 bytes in one frame wrap to the start of the same page, and for each slot the last byte written wins.
- R5: A commit with permit high in a frame holding at least one byte raises busy on the next clock.
- R6: A commit with permit low, or with no complete byte held, starts no cycle and discards the frame.
- R7: abort high in an open frame discards it, so a later commit writes nothing.
- R8: A cycle writes each filled slot exactly once, only within the frame's page, and leaves every other array byte unchanged.
- R9: busy stays high for exactly WR_CYCLES clocks (at least 16). done is high for one clock, on the last busy clock. The buffer is then empty.
- R10: While busy, start_vld, byte_vld, commit and abort have no effect. The cycle runs to its normal length and writes only the committed data.
- R11: A byte_vld in the same clock as commit is discarded as a partial byte. A byte_vld with no open frame is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_vld | input | 1 | Opens a frame at start_addr |
| start_addr | input | 9 | First array address of the frame |
| byte_vld | input | 1 | One complete data byte is present |
| byte_data | input | 8 | Data byte |
| commit | input | 1 | Chip-select rising edge strobe |
| permit | input | 1 | Protection logic allows the write |
| abort | input | 1 | Cancels the open frame |
| busy | output | 1 | Programming cycle in progress |
| done | output | 1 | One-clock pulse at the end of the cycle |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | 9 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
Directed frames cover a single byte, a full aligned page, and a 20-byte burst that starts at offset 10. The burst separates correct in-page wrapping from carry into the page bits and from missed overwrites. Frames with no bytes, with permit low, and with an abort part-way through must leave busy low and the array untouched. This shows that commit depends on all three conditions. Other frames place a byte in the commit clock, send a byte with no frame open, restart a frame, and inject inputs during busy. These show whether partial or stray data leaks into the array. Random frames with mixed lengths, offsets, permits and aborts are then checked against a bench model of the array, comparing each page and the full array at the end.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_PROG = 2'd2
  } pg_state_e;
endpackage

// File: rtl/pgbuf_rst_sync.sv
module pgbuf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic s0_q, s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q <= 1'b0;
      s1_q <= 1'b0;
    end else begin
      s0_q <= 1'b1;
      s1_q <= s0_q;
    end
  end

  assign rst_int_n = s1_q;
endmodule

// File: rtl/pgbuf_addr.sv
// Holds the page number and the wrapping in-page offset.
module pgbuf_addr #(
  parameter int ADDR_W = 9,
  parameter int OFS_W  = 4,
  localparam int PAGE_W = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step,
  output logic [PAGE_W-1:0] page,
  output logic [OFS_W-1:0]  ofs
);
  logic [PAGE_W-1:0] page_q, page_d;
  logic [OFS_W-1:0]  ofs_q, ofs_d;

  always_comb begin
    page_d = page_q;
    ofs_d  = ofs_q;
    if (load) begin
      page_d = load_addr[ADDR_W-1:OFS_W];
      ofs_d  = load_addr[OFS_W-1:0];
    end else if (step) begin
      ofs_d  = ofs_q + 1'b1;   // natural wrap inside the page
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      ofs_q  <= '0;
    end else if (load || step) begin
      page_q <= page_d;
      ofs_q  <= ofs_d;
    end
  end

  assign page = page_q;
  assign ofs  = ofs_q;
endmodule

// File: rtl/pgbuf_store.sv
// Slot storage with a per-slot fill mask.
module pgbuf_store #(
  parameter int SLOTS  = 16,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_hit,
  output logic              any_fill
);
  logic [SLOTS-1:0]  mask_q, mask_d;
  logic [DATA_W-1:0] data_q [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(s));

    always_comb begin
      if (clr)      mask_d[s] = 1'b0;
      else if (hit) mask_d[s] = 1'b1;
      else          mask_d[s] = mask_q[s];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           mask_q[s] <= 1'b0;
      else if (clr || hit)  mask_q[s] <= mask_d[s];
    end

    always_ff @(posedge clk) begin
      if (hit) data_q[s] <= wr_data;
    end
  end

  assign rd_data  = data_q[rd_idx];
  assign rd_hit   = mask_q[rd_idx];
  assign any_fill = |mask_q;
endmodule

// File: rtl/pgbuf_timer.sv
// Cycle counter for the self-timed programming window.
module pgbuf_timer #(
  parameter int CYCLES = 40,
  parameter int CNT_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(CYCLES - 1);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign last = run && (cnt_q == LAST_C);

  always_comb begin
    if (!run || last) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pgbuf_commit.sv
module pgbuf_commit
  import pgbuf_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int PAGE_BYTES = 16,
  parameter int DATA_W     = 8,
  parameter int WR_CYCLES  = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_vld,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              commit,
  input  logic              permit,
  input  logic              abort,
  output logic              busy,
  output logic              done,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int OFS_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFS_W;
  // The scan needs one clock per slot, so the window never undercuts it.
  localparam int EFF_CYCLES = (WR_CYCLES < PAGE_BYTES) ? PAGE_BYTES : WR_CYCLES;
  localparam int CNT_W = $clog2(EFF_CYCLES + 1);
  localparam logic [CNT_W-1:0] SLOTS_C = CNT_W'(PAGE_BYTES);

  logic rst_int_n;
  pg_state_e state_q, state_d;

  logic              ld_addr, step_ofs, buf_wr, buf_clr, run, last;
  logic [PAGE_W-1:0] page;
  logic [OFS_W-1:0]  ofs;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] rd_data;
  logic              rd_hit, any_fill, in_scan;

  pgbuf_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  // Frame sequencing: abort wins over commit, commit over a new start,
  // and a new start over a data byte.
  always_comb begin
    state_d  = state_q;
    ld_addr  = 1'b0;
    step_ofs = 1'b0;
    buf_wr   = 1'b0;
    buf_clr  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_vld) begin
          state_d = ST_FILL;
          ld_addr = 1'b1;
          buf_clr = 1'b1;
        end
      end
      ST_FILL: begin
        if (abort) begin
          state_d = ST_IDLE;
          buf_clr = 1'b1;
        end else if (commit) begin
          if (permit && any_fill) begin
            state_d = ST_PROG;
          end else begin
            state_d = ST_IDLE;
            buf_clr = 1'b1;
          end
        end else if (start_vld) begin
          ld_addr = 1'b1;
          buf_clr = 1'b1;
        end else if (byte_vld) begin
          buf_wr   = 1'b1;
          step_ofs = 1'b1;
        end
      end
      ST_PROG: begin
        if (last) begin
          state_d = ST_IDLE;
          buf_clr = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= ST_IDLE;
    else            state_q <= state_d;
  end

  assign run = (state_q == ST_PROG);

  pgbuf_addr #(
    .ADDR_W (ADDR_W),
    .OFS_W  (OFS_W)
  ) u_addr (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load      (ld_addr),
    .load_addr (start_addr),
    .step      (step_ofs),
    .page      (page),
    .ofs       (ofs)
  );

  pgbuf_store #(
    .SLOTS  (PAGE_BYTES),
    .DATA_W (DATA_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clr      (buf_clr),
    .wr_en    (buf_wr),
    .wr_idx   (ofs),
    .wr_data  (byte_data),
    .rd_idx   (cnt[OFS_W-1:0]),
    .rd_data  (rd_data),
    .rd_hit   (rd_hit),
    .any_fill (any_fill)
  );

  pgbuf_timer #(
    .CYCLES (EFF_CYCLES),
    .CNT_W  (CNT_W)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_int_n),
    .run   (run),
    .cnt   (cnt),
    .last  (last)
  );

  // Scan the slots in the first PAGE_BYTES clocks of the window.
  assign in_scan   = (cnt < SLOTS_C);
  assign mem_we    = run && in_scan && rd_hit;
  assign mem_addr  = {page, cnt[OFS_W-1:0]};
  assign mem_wdata = rd_data;
  assign busy      = run;
  assign done      = last;
endmodule

// File: rtl/pgbuf_commit_chk.sv
module pgbuf_commit_chk #(
  parameter int ADDR_W     = 9,
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              commit,
  input logic              permit,
  input logic              busy,
  input logic              done,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);
  localparam int OFS_W = $clog2(PAGE_BYTES);
  localparam int EFF_CYCLES = (WR_CYCLES < PAGE_BYTES) ? PAGE_BYTES : WR_CYCLES;

  int unsigned busy_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= 0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= 0;
  end

  AST_RST_QUIET: assert property (@(posedge clk) !rst_n |-> (!busy && !done && !mem_we)); // R1
  AST_WE_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> busy); // R8
  AST_SAME_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr[ADDR_W-1:OFS_W] == $past(mem_addr[ADDR_W-1:OFS_W]))); // R8
  AST_START_NEEDS_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(commit) && $past(permit))); // R5
  AST_DONE_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> busy); // R9
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy); // R9
  AST_CYCLE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len == EFF_CYCLES)); // R9
endmodule

bind pgbuf_commit pgbuf_commit_chk #(
  .ADDR_W     (ADDR_W),
  .PAGE_BYTES (PAGE_BYTES),
  .WR_CYCLES  (WR_CYCLES)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .commit   (commit),
  .permit   (permit),
  .busy     (busy),
  .done     (done),
  .mem_we   (mem_we),
  .mem_addr (mem_addr)
);

// File: tb/pgbuf_commit_bench.sv
module pgbuf_commit_bench;
  localparam int WRC = 40;

  logic       clk, rst_n;
  logic       start_vld, byte_vld, commit, permit, abort;
  logic [8:0] start_addr;
  logic [7:0] byte_data;
  logic       busy, done, mem_we;
  logic [8:0] mem_addr;
  logic [7:0] mem_wdata;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] ram [512];
  logic [7:0] exp_mem [512];

  pgbuf_commit #(.WR_CYCLES(WRC)) u_pgbuf_commit (
    .clk(clk), .rst_n(rst_n), .start_vld(start_vld), .start_addr(start_addr),
    .byte_vld(byte_vld), .byte_data(byte_data), .commit(commit),
    .permit(permit), .abort(abort), .busy(busy), .done(done),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] init_val(int a);
    return 8'((a * 7 + 3) ^ (a >> 3));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 512; i++) ram[i] <= init_val(i);
    end else if (mem_we) begin
      ram[mem_addr] <= mem_wdata;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int page_mismatch(input logic [4:0] pg);
    int bad = 0;
    for (int k = 0; k < 16; k++)
      if (ram[{pg, 4'(k)}] !== exp_mem[{pg, 4'(k)}]) bad++;
    return bad;
  endfunction

  // One frame: optional stray/restart prelude, n bytes, commit, then the cycle.
  task automatic run_frame(input logic [8:0] a, input int n, input bit perm,
                           input int abort_at, input bit same_byte,
                           input bit junk, input bit prelude);
    logic [7:0] tmp [16];
    logic [15:0] mask = '0;
    logic [3:0] ptr = a[3:0];
    bit aborted = 0;
    bit go;
    int cycles = 0, dones = 0, writes = 0;
    if (prelude) begin
      @(negedge clk); byte_vld = 1; byte_data = 8'hEE;        // R11: no frame open
      @(negedge clk); byte_vld = 0; start_vld = 1; start_addr = a ^ 9'h150;
      for (int i = 0; i < 3; i++) begin                        // R2: bytes to be discarded
        @(negedge clk); start_vld = 0; byte_vld = 1; byte_data = 8'(8'h90 + i);
      end
      @(negedge clk); byte_vld = 0;
    end
    @(negedge clk); start_vld = 1; start_addr = a;
    @(negedge clk); start_vld = 0;
    for (int i = 0; i < n; i++) begin
      if (i == abort_at) begin
        abort = 1; @(negedge clk); abort = 0; aborted = 1;
      end
      byte_vld = 1; byte_data = 8'($urandom);
      if (!aborted) begin
        tmp[ptr] = byte_data; mask[ptr] = 1'b1; ptr = ptr + 4'd1;
      end
      @(negedge clk); byte_vld = 0;
    end
    commit = 1; permit = perm;
    if (same_byte) begin byte_vld = 1; byte_data = 8'h5A; end
    @(negedge clk); commit = 0; byte_vld = 0; permit = 1'($urandom);
    go = perm && !aborted && (mask != 0);
    check(busy == go, go ? "R5 busy after commit" : "R6/R7 no cycle", int'(busy), int'(go));
    if (go) begin
      while (busy && cycles < 1000) begin
        cycles++;
        if (done) dones++;
        if (done && cycles != WRC) check(0, "R9 done position", cycles, WRC);
        if (mem_we) writes++;
        if (junk && cycles == 3) begin
          start_vld = 1; start_addr = ~a; byte_vld = 1; byte_data = 8'hC3;
          commit = 1; permit = 1; abort = 1;
        end
        @(negedge clk);
        start_vld = 0; byte_vld = 0; commit = 0; abort = 0;
      end
      check(cycles == WRC, "R9 busy length", cycles, WRC);
      check(dones == 1, "R9 done pulses", dones, 1);
      check(writes == $countones(mask), "R8 write count", writes, $countones(mask));
      for (int k = 0; k < 16; k++)
        if (mask[k]) exp_mem[{a[8:4], 4'(k)}] = tmp[k];
      repeat (2) @(negedge clk);
      check(!busy, junk ? "R10 no cycle from input seen while busy" : "R9 stays idle",
            int'(busy), 0);
    end else begin
      repeat (3) @(negedge clk);
      check(!busy, "R6/R7 still idle", int'(busy), 0);
    end
    check(page_mismatch(a[8:4]) == 0,
          n > 16 ? "R4 page contents" : "R3/R8 page contents",
          page_mismatch(a[8:4]), 0);
  endtask

  initial begin
    int bad;
    void'($urandom(32'h5EED1234));
    rst_n = 0; start_vld = 0; start_addr = '0; byte_vld = 0; byte_data = '0;
    commit = 0; permit = 0; abort = 0;
    for (int i = 0; i < 512; i++) exp_mem[i] = init_val(i);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(!busy && !done && !mem_we, "R1 reset outputs",
          int'({busy, done, mem_we}), 0);

    run_frame(9'h000, 1, 1, -1, 0, 0, 0);    // R3 single byte
    run_frame(9'h120, 16, 1, -1, 0, 0, 0);   // R3 full page
    run_frame(9'h0AA, 20, 1, -1, 0, 0, 0);   // R4 wrap from offset 10
    run_frame(9'h1F0, 0, 1, -1, 0, 0, 0);    // R6 no bytes
    run_frame(9'h040, 5, 0, -1, 0, 0, 0);    // R6 permit low
    run_frame(9'h083, 6, 1, 3, 0, 0, 0);     // R7 abort mid-frame
    run_frame(9'h1FE, 2, 1, -1, 1, 0, 0);    // R11 byte with commit dropped
    run_frame(9'h065, 4, 1, -1, 0, 1, 0);    // R10 inputs while busy
    run_frame(9'h0D7, 3, 1, -1, 0, 0, 1);    // R2 restart, R11 stray byte

    for (int f = 0; f < 40; f++) begin
      int n = int'($urandom_range(0, 24));
      int ab = ($urandom_range(0, 9) == 0) ? int'($urandom_range(0, 24)) : -1;
      run_frame(9'($urandom), n, ($urandom_range(0, 99) < 85), ab,
                ($urandom_range(0, 7) == 0), ($urandom_range(0, 2) == 0),
                ($urandom_range(0, 5) == 0));
    end

    bad = 0;
    for (int i = 0; i < 512; i++) if (ram[i] !== exp_mem[i]) bad++;
    check(bad == 0, "R8 whole array", bad, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule